// File: doc/BRIEF.md
# Capture/Compare Timer with One-Shot Pulse

This block is a 16-bit up-counter with two compare/capture registers, an overflow flag, edge selection on a trigger input, a second capture input, and a single timer output that can produce one-shot pulses. Software reaches it through a synchronous register bus: writes land on the clock edge, and reads return one cycle later. An external prescaler supplies a count-enable strobe. The counter advances only on cycles where that strobe is high.

A two-bit mode field selects one of four behaviours: stopped, free-running, clear-and-restart when the count equals compare register 0, or clear-and-restart on a selected edge of the trigger input. Both external inputs pass through a two-flop synchronizer before edge detection. A one-shot pulse starts from a self-clearing software bit or from a trigger edge. The counter clears and counts, the output rises on a match with compare register 1, and it falls on a match with compare register 0.

Top module: `cc_timer`

## Requirements
- R1: The register map is: address 0 is the counter (read only), 1 is compare 0, 2 is compare 1, 3 is control, and 4 is status (bit 0 is the overflow flag). The control fields are mode in bits 1:0, edge select in bits 3:2, capture-0 enable in bit 4, capture-1 enable in bit 5, one-shot enable in bit 6, the software trigger in bit 7, and the read-only one-shot-active bit in bit 8. A read presents its data on busRdata in the cycle after busRe; with no read, busRdata is zero. Mode 0 stops the counter and holds it at zero. Modes 1, 2 and 3 add one to the counter on each cycle where cntEn is high.
- R2: In mode 2, a counting cycle in which the counter equals compare 0 loads zero instead of incrementing.
- R3: A counting cycle in which the counter is FFFFh sets the overflow flag (also seen on ovfFlag). Any write to address 4 clears the flag, except as limited by R4.
- R4: After an overflow, writes to address 4 are ignored until the next counting cycle, so the flag stays set.
- R5: Edge select 00 selects no edge, 01 selects rising, 10 selects falling, and 11 selects both edges of trigIn. An input change acts at the third rising clock edge after it. In mode 3, a selected edge clears the counter to zero.
- R6: A write to address 3 updates the edge-select field only if the current mode is 0. At other times that field keeps its value while the rest of the write takes effect.
- R7: With capture-0 enabled, a selected trigIn edge copies the counter into compare 0. With capture-1 enabled, a rising capIn edge copies the counter into compare 1. A capture has priority over a bus write to the same register.
- R8: If a capture and a read of the same register fall in the same cycle, the captured value is stored, the read returns zero, and busRdErr pulses high with that read data.
- R9: Reading the counter never changes compare 1.
- R10: While in mode 0, edges on trigIn and capIn neither capture nor clear.
- R11: With one-shot enabled in mode 1 or 3, a software trigger bit (which self-clears after one cycle) or a selected trigIn edge clears the counter and starts a pulse. During the pulse, timerOut rises on a counting cycle where the counter equals compare 1, and it falls (ending the pulse) on a counting cycle where the counter equals compare 0. The compare 0 match wins when both match.
- R12: In mode 2, one-shot requests produce no pulse and timerOut stays low.
- R13: A software or edge trigger that arrives while a pulse is active is ignored: it neither clears the counter nor restarts the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count-enable strobe from the prescaler |
| trigIn | input | 1 | Asynchronous trigger input |
| capIn | input | 1 | Asynchronous capture input |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid the cycle after busRe |
| busRdErr | output | 1 | Read collided with a capture; data is zero |
| timerOut | output | 1 | One-shot pulse output |
| ovfFlag | output | 1 | Overflow flag |

## Verification
The hardest condition to reach is a read of compare 1 in the exact cycle that a capIn edge is stored. That edge is hidden behind the synchronizer delay. The bench raises capIn and waits two falling clock edges. It then asserts busRe so that the read lands on the third rising edge, the one where the capture fires. A second hard condition is the window just after a wrap where the overflow flag cannot be cleared. The bench counts to the wrap, drops cntEn on the very next cycle, and writes a clear while the counter sits at zero.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP0  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP1  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT  = 3'd4;

  typedef enum logic [1:0] {
    MODE_STOP  = 2'd0,
    MODE_FREE  = 2'd1,
    MODE_MATCH = 2'd2,
    MODE_EDGE  = 2'd3
  } tmrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic stop;
    logic clrCnt;
    logic incCnt;
    logic cap0;
    logic cap1;
    logic wrCmp0;
    logic wrCmp1;
  } dpCtl_t;

endpackage

// File: rtl/cc_timer_sync.sv
module cc_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic prev
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign prev  = pipe[STAGES];

endmodule

// File: rtl/cc_timer_dp.sv
module cc_timer_dp
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       ctl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp0,
  output logic [W-1:0] cmp1,
  output logic         cntMax,
  output logic         eq0,
  output logic         eq1
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.stop)   cnt <= '0;
    else if (ctl.clrCnt) cnt <= '0;
    else if (ctl.incCnt) cnt <= cnt + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cmp0 <= '0;
    else if (ctl.cap0)   cmp0 <= cnt;
    else if (ctl.wrCmp0) cmp0 <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cmp1 <= '0;
    else if (ctl.cap1)   cmp1 <= cnt;
    else if (ctl.wrCmp1) cmp1 <= wdata;
  end

  assign cntMax = &cnt;
  assign eq0    = (cnt == cmp0);
  assign eq1    = (cnt == cmp1);

  // R1
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stop |=> (cnt == '0));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incCnt && !ctl.clrCnt && !ctl.stop) |=> (cnt == $past(cnt) + ONE));

  // R7
  cap0_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cap0 |=> (cmp0 == $past(cnt)));

  // R7
  cap1_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cap1 |=> (cmp1 == $past(cnt)));

endmodule

// File: rtl/cc_timer_ctrl.sv
module cc_timer_ctrl
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cntEn,
  input  logic                  trigLvl,
  input  logic                  trigPrev,
  input  logic                  capLvl,
  input  logic                  capPrev,
  input  logic                  busWe,
  input  logic                  busRe,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [7:0]            wdCtrl,
  input  logic [W-1:0]          cnt,
  input  logic [W-1:0]          cmp0,
  input  logic [W-1:0]          cmp1,
  input  logic                  cntMax,
  input  logic                  eq0,
  input  logic                  eq1,
  output dpCtl_t                ctl,
  output logic [W-1:0]          busRdata,
  output logic                  busRdErr,
  output logic                  timerOut,
  output logic                  ovfFlag
);

  tmrMode_e   modeQ;
  logic [1:0] edgeSelQ;
  logic       c0EnQ, c1EnQ, osEnQ, swTrigQ;
  logic       ovfQ, blkQ, osActQ, outQ;

  logic running, trigRise, trigFall, trigSel, trigEdge, capEdge;
  logic osOk, osStart, trigClr, tick, matchClr, wrap;
  logic wrCtrl, wrStat, cap0, cap1;
  logic [W-1:0] ctrlWord, rdNext;
  logic         errNext;

  assign running  = (modeQ != MODE_STOP);
  assign trigRise = trigLvl & ~trigPrev;
  assign trigFall = ~trigLvl & trigPrev;

  always_comb begin
    case (edgeSelQ)
      2'b01:   trigSel = trigRise;
      2'b10:   trigSel = trigFall;
      2'b11:   trigSel = trigRise | trigFall;
      default: trigSel = 1'b0;
    endcase
  end

  assign trigEdge = running & trigSel;
  assign capEdge  = running & capLvl & ~capPrev;

  assign osOk     = osEnQ & ((modeQ == MODE_FREE) | (modeQ == MODE_EDGE));
  assign osStart  = osOk & ~osActQ & (swTrigQ | trigEdge);
  assign trigClr  = osStart | ((modeQ == MODE_EDGE) & trigEdge & ~(osOk & osActQ));
  assign tick     = running & cntEn;
  assign matchClr = tick & (modeQ == MODE_MATCH) & eq0;
  assign wrap     = tick & cntMax & ~trigClr;

  assign cap0   = c0EnQ & trigEdge;
  assign cap1   = c1EnQ & capEdge;
  assign wrCtrl = busWe & (busAddr == ADDR_CTRL);
  assign wrStat = busWe & (busAddr == ADDR_STAT);

  always_comb begin
    ctl.stop   = ~running;
    ctl.clrCnt = trigClr | matchClr;
    ctl.incCnt = tick;
    ctl.cap0   = cap0;
    ctl.cap1   = cap1;
    ctl.wrCmp0 = busWe & (busAddr == ADDR_CMP0);
    ctl.wrCmp1 = busWe & (busAddr == ADDR_CMP1);
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_STOP;
      edgeSelQ <= 2'b00;
      c0EnQ    <= 1'b0;
      c1EnQ    <= 1'b0;
      osEnQ    <= 1'b0;
      swTrigQ  <= 1'b0;
    end else begin
      swTrigQ <= wrCtrl & wdCtrl[7];
      if (wrCtrl) begin
        modeQ <= tmrMode_e'(wdCtrl[1:0]);
        c0EnQ <= wdCtrl[4];
        c1EnQ <= wdCtrl[5];
        osEnQ <= wdCtrl[6];
        if (!running) edgeSelQ <= wdCtrl[3:2];
      end
    end
  end

  // overflow flag with clear lockout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
      blkQ <= 1'b0;
    end else begin
      if (wrap)                ovfQ <= 1'b1;
      else if (wrStat && !blkQ) ovfQ <= 1'b0;
      if (wrap)      blkQ <= 1'b1;
      else if (tick) blkQ <= 1'b0;
    end
  end

  // one-shot sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      osActQ <= 1'b0;
      outQ   <= 1'b0;
    end else if (!running || !osOk) begin
      osActQ <= 1'b0;
      outQ   <= 1'b0;
    end else if (osStart) begin
      osActQ <= 1'b1;
      outQ   <= 1'b0;
    end else if (osActQ && tick) begin
      if (eq0) begin
        osActQ <= 1'b0;
        outQ   <= 1'b0;
      end else if (eq1) begin
        outQ <= 1'b1;
      end
    end
  end

  // read path, one cycle latency
  assign ctrlWord = {{(W-9){1'b0}}, osActQ, swTrigQ, osEnQ, c1EnQ, c0EnQ, edgeSelQ, modeQ};

  always_comb begin
    rdNext  = '0;
    errNext = 1'b0;
    if (busRe) begin
      case (busAddr)
        ADDR_COUNT: rdNext = cnt;
        ADDR_CMP0:  if (cap0) errNext = 1'b1; else rdNext = cmp0;
        ADDR_CMP1:  if (cap1) errNext = 1'b1; else rdNext = cmp1;
        ADDR_CTRL:  rdNext = ctrlWord;
        ADDR_STAT:  rdNext = {{(W-1){1'b0}}, ovfQ};
        default:    rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      busRdErr <= 1'b0;
    end else begin
      busRdata <= rdNext;
      busRdErr <= errNext;
    end
  end

  assign timerOut = outQ;
  assign ovfFlag  = ovfQ;

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> ovfFlag);

  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blkQ && ovfQ) |=> ovfQ);

  // R6
  edge_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_STOP) |=> $stable(edgeSelQ));

  // R12
  match_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_MATCH) |=> !timerOut);

  // R8
  rd_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdErr |-> (busRdata == '0));

  // R11
  out_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerOut |-> osActQ);

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cntEn,
  input  logic                  trigIn,
  input  logic                  capIn,
  input  logic                  busWe,
  input  logic                  busRe,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [W-1:0]          busWdata,
  output logic [W-1:0]          busRdata,
  output logic                  busRdErr,
  output logic                  timerOut,
  output logic                  ovfFlag
);

  localparam int N_IN = 2;

  logic [N_IN-1:0] rawIn, syncLvl, syncPrev;
  dpCtl_t          ctl;
  logic [W-1:0]    cnt, cmp0, cmp1;
  logic            cntMax, eq0, eq1;

  assign rawIn = {capIn, trigIn};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    cc_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rstN  (rstN),
      .din   (rawIn[i]),
      .level (syncLvl[i]),
      .prev  (syncPrev[i])
    );
  end

  cc_timer_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntEn    (cntEn),
    .trigLvl  (syncLvl[0]),
    .trigPrev (syncPrev[0]),
    .capLvl   (syncLvl[1]),
    .capPrev  (syncPrev[1]),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .wdCtrl   (busWdata[7:0]),
    .cnt      (cnt),
    .cmp0     (cmp0),
    .cmp1     (cmp1),
    .cntMax   (cntMax),
    .eq0      (eq0),
    .eq1      (eq1),
    .ctl      (ctl),
    .busRdata (busRdata),
    .busRdErr (busRdErr),
    .timerOut (timerOut),
    .ovfFlag  (ovfFlag)
  );

  cc_timer_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wdata  (busWdata),
    .cnt    (cnt),
    .cmp0   (cmp0),
    .cmp1   (cmp1),
    .cntMax (cntMax),
    .eq0    (eq0),
    .eq1    (eq1)
  );

endmodule

// File: tb/sim_cc_timer.sv
`timescale 1ns/1ps
module sim_cc_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0, trigIn = 1'b0, capIn = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busRdErr, timerOut, ovfFlag;

  int tests = 0, fails = 0, hiCnt = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cc_timer u0 (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .trigIn(trigIn), .capIn(capIn),
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busRdErr(busRdErr), .timerOut(timerOut), .ovfFlag(ovfFlag)
  );

  // behavioural reference state
  logic [15:0] mCnt, mCmp0, mCmp1, mRd;
  logic [1:0]  mMode, mEdge;
  bit mC0En, mC1En, mOsEn, mSw, mOvf, mBlk, mOsAct, mOut, mErr;
  bit mT1, mT2, mT3, mK1, mK2, mK3;

  always @(posedge clk) begin : refModel
    bit run, tE, cE, osOk, osStart, tClr, tick, mClr, wrap, cap0, cap1, nErr;
    logic [15:0] nRd;
    if (!rstN) begin
      mCnt = 0; mCmp0 = 0; mCmp1 = 0; mRd = 0; mMode = 0; mEdge = 0;
      mC0En = 0; mC1En = 0; mOsEn = 0; mSw = 0; mOvf = 0; mBlk = 0;
      mOsAct = 0; mOut = 0; mErr = 0;
      mT1 = 0; mT2 = 0; mT3 = 0; mK1 = 0; mK2 = 0; mK3 = 0;
    end else begin
      run  = (mMode != 0);
      tE   = run && ((mEdge == 1 && mT2 && !mT3) || (mEdge == 2 && !mT2 && mT3) ||
                     (mEdge == 3 && (mT2 != mT3)));
      cE   = run && mK2 && !mK3;
      osOk = mOsEn && (mMode == 1 || mMode == 3);
      osStart = osOk && !mOsAct && (mSw || tE);
      tClr = osStart || (mMode == 3 && tE && !(osOk && mOsAct));
      tick = run && cntEn;
      mClr = tick && mMode == 2 && mCnt == mCmp0;
      wrap = tick && mCnt == 16'hFFFF && !tClr;
      cap0 = mC0En && tE;
      cap1 = mC1En && cE;
      nRd = 0; nErr = 0;
      if (busRe) begin
        case (busAddr)
          3'd0: nRd = mCnt;
          3'd1: if (cap0) nErr = 1; else nRd = mCmp0;
          3'd2: if (cap1) nErr = 1; else nRd = mCmp1;
          3'd3: nRd = {7'd0, mOsAct, mSw, mOsEn, mC1En, mC0En, mEdge, mMode};
          3'd4: nRd = {15'd0, mOvf};
          default: nRd = 0;
        endcase
      end
      if (!run || !osOk) begin mOsAct = 0; mOut = 0; end
      else if (osStart) begin mOsAct = 1; mOut = 0; end
      else if (mOsAct && tick) begin
        if (mCnt == mCmp0) begin mOsAct = 0; mOut = 0; end
        else if (mCnt == mCmp1) mOut = 1;
      end
      if (wrap) mOvf = 1;
      else if (busWe && busAddr == 3'd4 && !mBlk) mOvf = 0;
      if (wrap) mBlk = 1; else if (tick) mBlk = 0;
      if (cap0) mCmp0 = mCnt; else if (busWe && busAddr == 3'd1) mCmp0 = busWdata;
      if (cap1) mCmp1 = mCnt; else if (busWe && busAddr == 3'd2) mCmp1 = busWdata;
      if (!run) mCnt = 0;
      else if (tClr || mClr) mCnt = 0;
      else if (tick) mCnt = mCnt + 16'd1;
      mSw = busWe && busAddr == 3'd3 && busWdata[7];
      if (busWe && busAddr == 3'd3) begin
        if (!run) mEdge = busWdata[3:2];
        mMode = busWdata[1:0];
        mC0En = busWdata[4]; mC1En = busWdata[5]; mOsEn = busWdata[6];
      end
      mT3 = mT2; mT2 = mT1; mT1 = trigIn;
      mK3 = mK2; mK2 = mK1; mK1 = capIn;
      mRd = nRd; mErr = nErr;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1 rdata", busRdata, mRd);
      chk("R8 rdErr", busRdErr, mErr);
      chk("R3 ovfFlag", ovfFlag, mOvf);
      chk("R11 timerOut", timerOut, mOut);
      if (timerOut) hiCnt++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      fails++;
      tests++;
      done = 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    busRe = 1; busAddr = a;
    @(negedge clk);
    busRe = 0;
    d = busRdata;
  endtask

  initial begin
    logic [15:0] v, a0, a1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(3'd3, v); chk("R1 reset ctrl", v, 0);
    rd(3'd0, v); chk("R1 reset count", v, 0);
    chk("R3 reset ovf", ovfFlag, 0);
    chk("R11 reset out", timerOut, 0);

    // R1 free-run with gapped count enable
    wr(3'd3, 16'h0001);
    for (int i = 0; i < 20; i++) begin
      cntEn = (i % 2 == 1);
      @(negedge clk);
    end
    cntEn = 0;
    rd(3'd0, v); chk("R1 gapped count", v, 10);

    // R2 match-clear
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'd5);
    wr(3'd3, 16'h0002);
    cntEn = 1; idle(23); cntEn = 0;
    rd(3'd0, v); chk("R2 count bounded by cmp0", (v <= 5) ? 1 : 0, 1);

    // R6 edge field locked while running
    wr(3'd3, 16'h0000);
    wr(3'd3, 16'h0005);
    wr(3'd3, 16'h0009);
    rd(3'd3, v); chk("R6 edge kept", v[3:2], 1);
    chk("R6 mode written", v[1:0], 1);

    // R5 / R7 edge-clear mode with captures
    wr(3'd3, 16'h0000);
    wr(3'd3, 16'h0037);
    cntEn = 1; idle(30);
    trigIn = 1; idle(4);
    rd(3'd0, v); chk("R5 cleared by edge", (v < 10) ? 1 : 0, 1);
    trigIn = 0;
    rd(3'd1, v); chk("R7 cmp0 captured", (v > 20) ? 1 : 0, 1);

    // R8 capture colliding with a read
    capIn = 1;
    @(negedge clk); @(negedge clk);
    busRe = 1; busAddr = 3'd2;
    @(negedge clk);
    busRe = 0;
    chk("R8 conflict err", busRdErr, 1);
    chk("R8 conflict data", busRdata, 0);
    rd(3'd2, v); chk("R7 cmp1 captured", (v != 0) ? 1 : 0, 1);
    chk("R8 capture stored", v, mCmp1);

    // R9 counter read leaves cmp1 alone
    capIn = 0;
    rd(3'd2, a1);
    rd(3'd0, v); rd(3'd0, v);
    rd(3'd2, v); chk("R9 cmp1 unchanged", v, a1);
    cntEn = 0;

    // R10 stopped ignores inputs
    wr(3'd3, 16'h0030);
    rd(3'd1, a0); rd(3'd2, a1);
    for (int i = 0; i < 3; i++) begin
      trigIn = 1; capIn = 1; idle(4);
      trigIn = 0; capIn = 0; idle(4);
    end
    rd(3'd1, v); chk("R10 cmp0 held", v, a0);
    rd(3'd2, v); chk("R10 cmp1 held", v, a1);
    rd(3'd0, v); chk("R10 count zero", v, 0);

    // R3 / R4 overflow and clear lockout
    wr(3'd1, 16'hFFFF);
    wr(3'd3, 16'h0002);
    cntEn = 1;
    while (!mOvf) @(negedge clk);
    cntEn = 0;
    chk("R3 ovf set", ovfFlag, 1);
    wr(3'd4, 16'h0000);
    chk("R4 clear ignored", ovfFlag, 1);
    cntEn = 1; @(negedge clk); cntEn = 0;
    wr(3'd4, 16'h0000);
    chk("R3 clear works", ovfFlag, 0);

    // R11 software one-shot
    wr(3'd3, 16'h0000);
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd8);
    wr(3'd3, 16'h0041);
    cntEn = 1;
    hiCnt = 0;
    wr(3'd3, 16'h00C1);
    idle(30);
    chk("R11 sw pulse width", hiCnt, 5);

    // R13 software retrigger ignored
    hiCnt = 0;
    wr(3'd3, 16'h00C1);
    idle(2);
    wr(3'd3, 16'h00C1);
    idle(30);
    chk("R13 sw retrigger", hiCnt, 5);

    // R12 no pulse in match mode
    wr(3'd3, 16'h0000);
    wr(3'd3, 16'h0042);
    hiCnt = 0;
    wr(3'd3, 16'h00C2);
    idle(30);
    chk("R12 no pulse", hiCnt, 0);

    // R11 edge-started one-shot
    wr(3'd3, 16'h0000);
    wr(3'd3, 16'h0047);
    hiCnt = 0;
    trigIn = 1; idle(30);
    chk("R11 edge pulse width", hiCnt, 5);

    // R13 edge retrigger ignored
    trigIn = 0; idle(4);
    hiCnt = 0;
    trigIn = 1; idle(5);
    trigIn = 0; idle(1);
    trigIn = 1; idle(30);
    chk("R13 edge retrigger", hiCnt, 5);

    cntEn = 0;
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule